// File: doc/BRIEF.md
# MFM Sector Mark Synchroniser

This block watches the stream of recovered channel cells coming out of an MFM read path, one cell per strobe, and finds where a sector field starts. A field opens with a long stretch of encoded zero data. On the channel that stretch is a plain alternation of cells. The block first has to see enough of that alternation. Only then does it look for one of two 16-cell sync patterns. Each pattern is a mark byte written with one clock transition deliberately left out, so ordinary data cannot produce it. Which pattern matched tells the consumer whether a sector header or sector data follows.

The preamble is symmetric, so it cannot fix byte alignment by itself. Alignment is fixed by the mark. From the matching cell on, the block emits a byte strobe every 16 channel cells and stays locked to that grid until the read path asserts resync. If the preamble ends and no mark follows within 16 cells, the block gives up and hunts for a fresh preamble.

Top module: `mfm_mark_sync`

## Requirements
- R1: `pre_seen` goes high in the cycle after the strobed cell that completes 64 consecutive alternating cells (each cell differs from the one before, which is 32 pairs of 1,0). It is still low after 63 such cells.
- R2: A strobed cell equal to the previous cell restarts the alternation count, counting itself as the first cell of a new run. While `pre_seen` is low, mark patterns are ignored and `mark_found` stays low.
- R3: While searching, if the 16 most recent cells (the oldest cell in bit 15) equal 16'h4489, `mark_found` pulses high for exactly one cycle, in the cycle after that cell, and `mark_type` becomes 0 (header).
- R4: While searching, a match on 16'h4442 gives the same pulse with `mark_type` = 1 (data). `mark_type` holds its value until the next match or a resync.
- R5: Once locked, `byte_stb` pulses for one cycle after every 16th strobed cell counted from the matching cell, and at no other time.
- R6: Once locked, `mark_found` never pulses again and `pre_seen` stays high, whatever cells arrive.
- R7: `resync` returns the block to hunting in the next cycle: `pre_seen`, `byte_stb` and `mark_type` read 0, and a complete new preamble is needed before any match.
- R8: While searching, after the first cell that breaks the alternation, 16 strobed cells (the breaking cell included) with no match drop `pre_seen` to 0 in the cycle after the 16th cell.
- R9: After reset, all outputs are 0.
- R10: Cycles with `chan_stb` low change no state. They neither advance the byte count nor the preamble count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_stb | input | 1 | Qualifies `chan_bit` as a new channel cell |
| chan_bit | input | 1 | Recovered channel cell (1 = flux transition) |
| resync | input | 1 | Drop lock and hunt for a new preamble |
| pre_seen | output | 1 | High while the block is searching for a mark or is locked |
| mark_found | output | 1 | One-cycle pulse when a mark matches |
| mark_type | output | 1 | Type of the last mark: 0 header, 1 data |
| byte_stb | output | 1 | One-cycle pulse on each 16-cell byte boundary after lock |

## Verification
The checks target state errors that are visible at the ports. A preamble counter that is off by one shows up as `pre_seen` rising one cell early or one cell late. A run count that is not cleared shows up after a broken preamble, when `pre_seen` rises too soon. A wrong cell phase after lock moves every `byte_stb` within the first 16 cells. A search timeout that is off by one changes the cell on which `pre_seen` falls. A missing gate on the matcher shows up as `mark_found` pulsing without a preamble or a second time while locked. Each of these errors can be seen within at most one byte time of its cause.

// File: rtl/mms_pkg.sv
package mms_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCK   = 2'd2
    } sync_state_e;

    typedef enum logic {
        MK_HEADER = 1'b0,
        MK_DATA   = 1'b1
    } mark_kind_e;

    typedef struct packed {
        logic       hit;
        mark_kind_e kind;
    } mark_res_t;

    function automatic logic cells_alternate(input logic prev_cell, input logic cur_cell);
        return prev_cell != cur_cell;
    endfunction

endpackage

// File: rtl/mms_preamble.sv
module mms_preamble import mms_pkg::*; #(
    parameter int PRE_CELLS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic cell_vld,
    input  logic cell_bit,
    output logic pre_done,
    output logic brk
);
    localparam int CW = $clog2(PRE_CELLS + 1);
    localparam logic [CW-1:0] FULL = CW'(PRE_CELLS);

    logic          prev_q;
    logic          have_prev_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;
    logic          alt;

    assign alt = have_prev_q && cells_alternate(prev_q, cell_bit);
    assign brk = cell_vld && have_prev_q && !alt;

    always_comb begin
        if (!alt)
            run_d = CW'(1);
        else if (run_q == FULL)
            run_d = FULL;
        else
            run_d = run_q + CW'(1);
    end

    assign pre_done = cell_vld && (run_d == FULL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
            run_q       <= '0;
        end else if (cell_vld) begin
            prev_q      <= cell_bit;
            have_prev_q <= 1'b1;
            run_q       <= run_d;
        end
    end
endmodule

// File: rtl/mms_mark_match.sv
module mms_mark_match import mms_pkg::*; #(
    parameter int                    CELLS    = 16,
    parameter logic [CELLS-1:0]      HDR_MARK = 16'h4489,
    parameter logic [CELLS-1:0]      DAT_MARK = 16'h4442
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      cell_vld,
    input  logic      cell_bit,
    output mark_res_t res
);
    localparam int NUM_MARKS = 2;
    localparam logic [NUM_MARKS-1:0][CELLS-1:0] PATS = {DAT_MARK, HDR_MARK};

    logic [CELLS-1:0]     win_q;
    logic [CELLS-1:0]     win_d;
    logic [NUM_MARKS-1:0] hits;

    assign win_d = {win_q[CELLS-2:0], cell_bit};

    for (genvar g = 0; g < NUM_MARKS; g++) begin : g_cmp
        assign hits[g] = (win_d == PATS[g]);
    end

    assign res.hit  = cell_vld && (|hits);
    assign res.kind = hits[1] ? MK_DATA : MK_HEADER;

    always_ff @(posedge clk) begin
        if (rst || clr)
            win_q <= '0;
        else if (cell_vld)
            win_q <= win_d;
    end
endmodule

// File: rtl/mms_byte_timer.sv
module mms_byte_timer #(
    parameter int BYTE_CELLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic cell_vld,
    output logic tick
);
    localparam int BW = $clog2(BYTE_CELLS);
    localparam logic [BW-1:0] LAST = BW'(BYTE_CELLS - 1);

    logic [BW-1:0] cnt_q;

    assign tick = run && cell_vld && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && cell_vld)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + BW'(1);
    end
endmodule

// File: rtl/mfm_mark_sync.sv
module mfm_mark_sync import mms_pkg::*; #(
    parameter int                    PRE_CELLS  = 64,
    parameter int                    MARK_CELLS = 16,
    parameter logic [MARK_CELLS-1:0] HDR_MARK   = 16'h4489,
    parameter logic [MARK_CELLS-1:0] DAT_MARK   = 16'h4442,
    parameter int                    BYTE_CELLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic chan_stb,
    input  logic chan_bit,
    input  logic resync,
    output logic pre_seen,
    output logic mark_found,
    output logic mark_type,
    output logic byte_stb
);
    localparam int GW = $clog2(MARK_CELLS + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(MARK_CELLS - 1);

    sync_state_e state_q, state_d;
    logic [GW-1:0] gap_q, gap_d;
    mark_kind_e  kind_q, kind_d;
    logic        found_q, found_d;
    logic        stb_q;
    logic        pre_done, brk, tick;
    mark_res_t   mres;

    mms_preamble #(.PRE_CELLS(PRE_CELLS)) u_pre (
        .clk(clk), .rst(rst), .clr(resync),
        .cell_vld(chan_stb), .cell_bit(chan_bit),
        .pre_done(pre_done), .brk(brk)
    );

    mms_mark_match #(.CELLS(MARK_CELLS), .HDR_MARK(HDR_MARK), .DAT_MARK(DAT_MARK)) u_match (
        .clk(clk), .rst(rst), .clr(resync),
        .cell_vld(chan_stb), .cell_bit(chan_bit),
        .res(mres)
    );

    mms_byte_timer #(.BYTE_CELLS(BYTE_CELLS)) u_bt (
        .clk(clk), .rst(rst), .clr(resync || found_d),
        .run(state_q == ST_LOCK), .cell_vld(chan_stb),
        .tick(tick)
    );

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_HUNT: begin
                gap_d = '0;
                if (pre_done) state_d = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (mres.hit) begin
                    state_d = ST_LOCK;
                    gap_d   = '0;
                end else if (chan_stb && (brk || gap_q != '0)) begin
                    if (gap_q == GAP_LAST) begin
                        state_d = ST_HUNT;
                        gap_d   = '0;
                    end else begin
                        gap_d = gap_q + GW'(1);
                    end
                end
            end
            ST_LOCK: state_d = ST_LOCK;
            default: state_d = ST_HUNT;
        endcase
        if (resync) begin
            state_d = ST_HUNT;
            gap_d   = '0;
        end
    end

    assign found_d = (state_q == ST_SEARCH) && mres.hit && !resync;

    always_comb begin
        kind_d = kind_q;
        if (resync)       kind_d = MK_HEADER;
        else if (found_d) kind_d = mres.kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            gap_q   <= '0;
            kind_q  <= MK_HEADER;
            found_q <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
            kind_q  <= kind_d;
            found_q <= found_d;
            stb_q   <= tick && !resync;
        end
    end

    assign pre_seen   = (state_q != ST_HUNT);
    assign mark_found = found_q;
    assign mark_type  = kind_q;
    assign byte_stb   = stb_q;
endmodule

// File: rtl/mms_checker.sv
module mms_checker (
    input logic clk,
    input logic rst,
    input logic chan_stb,
    input logic resync,
    input logic pre_seen,
    input logic mark_found,
    input logic mark_type,
    input logic byte_stb
);
    // R1: the preamble flag only rises after a strobed cell
    p_pre_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_seen) |-> $past(chan_stb));

    // R3: a match pulse needs a confirmed preamble before and after it
    p_hit_needs_pre_r3: assert property (@(posedge clk) disable iff (rst)
        mark_found |-> (pre_seen && $past(pre_seen) && $past(chan_stb)));

    // R4: the mark type only changes on a match or after resync
    p_kind_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!mark_found && !$past(resync)) |-> $stable(mark_type));

    // R5: byte strobes only while locked and after a strobed cell
    p_stb_locked_r5: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> (pre_seen && $past(chan_stb)));

    // R6: the match pulse lasts one cycle and does not repeat at once
    p_hit_single_r6: assert property (@(posedge clk) disable iff (rst)
        mark_found |=> !mark_found);

    // R7: resync clears the flags on the next cycle
    p_resync_r7: assert property (@(posedge clk) disable iff (rst)
        resync |=> (!pre_seen && !byte_stb && !mark_found && !mark_type));

    // R10: a cycle without a strobe changes neither flag
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!chan_stb && !resync) |=> ($stable(pre_seen) && !mark_found && !byte_stb));
endmodule

bind mfm_mark_sync mms_checker chk_i (
    .clk(clk), .rst(rst), .chan_stb(chan_stb), .resync(resync),
    .pre_seen(pre_seen), .mark_found(mark_found),
    .mark_type(mark_type), .byte_stb(byte_stb)
);

// File: tb/mfm_mark_sync_tb_top.sv
module mfm_mark_sync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] HDR = 16'h4489;
    localparam logic [15:0] DAT = 16'h4442;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chan_stb = 1'b0;
    logic chan_bit = 1'b0;
    logic resync = 1'b0;
    logic pre_seen, mark_found, mark_type, byte_stb;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfm_mark_sync dut_i (
        .clk(clk), .rst(rst), .chan_stb(chan_stb), .chan_bit(chan_bit),
        .resync(resync), .pre_seen(pre_seen), .mark_found(mark_found),
        .mark_type(mark_type), .byte_stb(byte_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge, after the cell is taken.
    task automatic send_cell(input logic b);
        chan_stb = 1'b1;
        chan_bit = b;
        @(negedge clk);
        chan_stb = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic send_alt(input int n, input logic first);
        for (int i = 0; i < n; i++) send_cell(first ^ logic'(i[0]));
    endtask

    task automatic send_mark(input logic [15:0] p, input int exp_last, input string req);
        for (int i = 15; i >= 0; i--) begin
            send_cell(p[i]);
            if (i != 0) check(req, int'(mark_found), 0);
        end
        check(req, int'(mark_found), exp_last);
    endtask

    task automatic do_resync();
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        check("R7 pre_seen", int'(pre_seen), 0);
        check("R7 byte_stb", int'(byte_stb), 0);
        check("R7 mark_type", int'(mark_type), 0);
    endtask

    task automatic t_reset();
        check("R9 pre_seen", int'(pre_seen), 0);
        check("R9 mark_found", int'(mark_found), 0);
        check("R9 mark_type", int'(mark_type), 0);
        check("R9 byte_stb", int'(byte_stb), 0);
    endtask

    task automatic t_header_lock();
        int stb_errs;
        send_alt(63, 1'b1);
        check("R1 after 63 cells", int'(pre_seen), 0);
        send_cell(1'b0);
        check("R1 after 64 cells", int'(pre_seen), 1);
        send_mark(HDR, 1, "R3 header match");
        check("R3 header type", int'(mark_type), 0);
        send_cell(1'b1);
        check("R6 single pulse", int'(mark_found), 0);
        check("R5 no strobe on cell 1", int'(byte_stb), 0);
        stb_errs = 0;
        for (int k = 2; k <= 48; k++) begin
            send_cell(logic'(k[0]));
            if (int'(byte_stb) != ((k % 16 == 0) ? 1 : 0)) stb_errs++;
            if (k % 5 == 0) begin
                idle_cycle();
                if (byte_stb) stb_errs++;
            end
        end
        check("R5 R10 byte strobe grid", stb_errs, 0);
        for (int i = 15; i >= 0; i--) begin
            send_cell(HDR[i]);
            check("R6 no hit when locked", int'(mark_found), 0);
        end
        check("R5 strobe after 64th cell", int'(byte_stb), 1);
        check("R6 pre_seen held", int'(pre_seen), 1);
    endtask

    task automatic t_data_lock();
        send_alt(64, 1'b1);
        check("R1 second preamble", int'(pre_seen), 1);
        send_alt(36, 1'b1);
        check("R1 longer preamble", int'(pre_seen), 1);
        send_mark(DAT, 1, "R4 data match");
        check("R4 data type", int'(mark_type), 1);
        send_alt(20, 1'b0);
        check("R4 type held", int'(mark_type), 1);
    endtask

    task automatic t_no_preamble();
        send_alt(20, 1'b1);
        send_mark(HDR, 0, "R2 mark ignored without preamble");
        check("R2 pre_seen low", int'(pre_seen), 0);
    endtask

    task automatic t_break_restart();
        send_alt(40, 1'b1);
        send_cell(1'b0);
        send_alt(62, 1'b1);
        check("R2 run restarted", int'(pre_seen), 0);
        send_cell(1'b1);
        check("R2 run complete", int'(pre_seen), 1);
    endtask

    task automatic t_timeout();
        send_cell(1'b1);
        for (int i = 0; i < 14; i++) send_cell(1'b0);
        check("R8 still searching after 15 cells", int'(pre_seen), 1);
        send_cell(1'b0);
        check("R8 dropped after 16 cells", int'(pre_seen), 0);
        send_mark(HDR, 0, "R8 no match after timeout");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_header_lock();
        do_resync();
        t_data_lock();
        do_resync();
        t_no_preamble();
        do_resync();
        t_break_restart();
        t_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule